// File: doc/BRIEF.md
# Direct-Control Start/Stop and Key-Entry Sequencer

This block sits in front of a cipher engine and turns a handful of dedicated control lines into start, stop and key-load actions, so a fast microcoded controller can run the engine without issuing bus commands. A mode input picks one of two meanings for the 8-bit auxiliary bus. In multiplexed mode the bus carries key bytes, strobed by `aux_wr_i`, into the encrypt-key register. In direct mode three of its lines are control lines: bit 5 is run (rise starts ciphering, fall stops), bit 6 is the direction/target select and bit 7 is key entry.

The select line is shared. At a run rise it picks encrypt (1) or decrypt (0). At a key-entry rise it picks the key register that following bytes on `data_i` load: encrypt (1) or decrypt (0). The select line is not latched by the user, so it has to stay stable while run or key entry is held. A change in that window raises an error flag.

A key is eight bytes, loaded from the most significant byte down. Each byte is checked for odd parity, with bit 0 as the parity bit.

Top module: `dcs_seq`

## Requirements
- R1: After reset, every output is 0, including both 64-bit key registers.
- R2: In direct mode, a 0-to-1 change on aux bit 5 between two clock edges gives a one-cycle pulse on `start_enc_o` if aux bit 6 is 1 at that edge, and on `start_dec_o` if it is 0. The pulse starts at the edge that samples the rise.
- R3: In direct mode, a 1-to-0 change on aux bit 5 gives a one-cycle `stop_o` pulse at the edge that samples the fall.
- R4: In multiplexed mode (`direct_mode_i`=0), aux bit 5 gives no start or stop events. Each `aux_wr_i` cycle writes `aux_i` into the encrypt-key register and pulses `enc_we_o`.
- R5: In direct mode, the edge that samples a rise of aux bit 7 latches aux bit 6 as the target (1 = encrypt, 0 = decrypt). From the next cycle, while bit 7 stays high, each `data_wr_i` cycle writes `data_i` into that register. The matching `enc_we_o` or `dec_we_o` pulses for one cycle at the write edge.
- R6: The bytes of a key fill the register from bits 63:56 down to bits 7:0, in that order.
- R7: `key_done_o` pulses together with the strobe of the eighth byte. The byte after it goes to bits 63:56 again. A key-entry rise also restarts the count at bits 63:56.
- R8: A written byte whose eight bits XOR to 0 sets `parity_err_o`. The flag stays set until reset or until a direct-mode key-entry rise.
- R9: In direct mode, a change of aux bit 6 while aux bit 5 or bit 7 is high at both this edge and the previous one sets `sel_err_o`. The next rise of aux bit 5 or bit 7 clears it.
- R10: In direct mode, `data_wr_i` with aux bit 7 low and `aux_wr_i` both write nothing. In multiplexed mode, `data_wr_i` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_mode_i | input | 1 | 1 = direct control, 0 = multiplexed key bus |
| aux_i | input | 8 | Auxiliary bus: key byte, or control lines on bits 5/6/7 |
| aux_wr_i | input | 1 | Key byte strobe for the aux bus in multiplexed mode |
| data_i | input | 8 | Key byte in direct mode |
| data_wr_i | input | 1 | Key byte strobe for `data_i` in direct mode |
| start_enc_o | output | 1 | Start-encrypt pulse |
| start_dec_o | output | 1 | Start-decrypt pulse |
| stop_o | output | 1 | Stop pulse |
| enc_we_o | output | 1 | Byte written to encrypt-key register |
| dec_we_o | output | 1 | Byte written to decrypt-key register |
| key_done_o | output | 1 | Eighth byte of a key written |
| parity_err_o | output | 1 | Sticky key-byte parity error |
| sel_err_o | output | 1 | Select line changed during an active operation |
| enc_key_o | output | 64 | Encrypt-key register |
| dec_key_o | output | 64 | Decrypt-key register |

## Verification
In direct mode the run decoder and the key loader work independently, so a start event and the final key byte can occur in the same cycle. The bench opens key entry toward the encrypt register and writes seven bytes. It then raises the run line with select high in the cycle that writes the eighth byte. The sample after that edge must show `start_enc_o`, `enc_we_o` and `key_done_o` all high, with the full key in place and no select error. The next byte must then land in the top byte.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned RUN_BIT = 5;
  localparam int unsigned SEL_BIT = 6;
  localparam int unsigned KEY_BIT = 7;
  typedef enum logic {TGT_DEC = 1'b0, TGT_ENC = 1'b1} key_tgt_e;
endpackage

// File: rtl/dcs_ctl.sv
module dcs_ctl
  import dcs_pkg::*;
#(
  parameter int unsigned AUX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             direct_i,
  input  logic [AUX_W-1:0] aux_i,
  output logic             start_enc_o,
  output logic             start_dec_o,
  output logic             stop_o,
  output logic             key_rise_o,
  output logic             key_open_o,
  output key_tgt_e         tgt_o,
  output logic             sel_err_o
);
  logic run, key, sel;
  logic run_q, key_q, sel_q;
  logic run_rise, run_fall, held;

  assign run = aux_i[RUN_BIT];
  assign key = aux_i[KEY_BIT];
  assign sel = aux_i[SEL_BIT];

  assign run_rise   = direct_i & run & ~run_q;
  assign run_fall   = direct_i & ~run & run_q;
  assign key_rise_o = direct_i & key & ~key_q;
  assign key_open_o = direct_i & key & key_q;
  // operation held across two edges: select must not move
  assign held       = direct_i & ((run & run_q) | (key & key_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      key_q       <= 1'b0;
      sel_q       <= 1'b0;
      start_enc_o <= 1'b0;
      start_dec_o <= 1'b0;
      stop_o      <= 1'b0;
      tgt_o       <= TGT_DEC;
      sel_err_o   <= 1'b0;
    end else begin
      run_q       <= run;
      key_q       <= key;
      sel_q       <= sel;
      start_enc_o <= run_rise & sel;
      start_dec_o <= run_rise & ~sel;
      stop_o      <= run_fall;
      if (key_rise_o) tgt_o <= sel ? TGT_ENC : TGT_DEC;
      if (held && (sel != sel_q)) sel_err_o <= 1'b1;
      else if (run_rise || key_rise_o) sel_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dcs_keyload.sv
module dcs_keyload #(
  parameter int unsigned KEY_BYTES = 8,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned CNT_W    = $clog2(KEY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CNT_W-1:0]  slot_o,
  output logic              last_o,
  output logic              par_err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_BYTES - 1);
  logic [CNT_W-1:0] cnt_q;

  assign slot_o = LAST - cnt_q;  // top byte first
  assign last_o = wr_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      par_err_o <= 1'b0;
    end else begin
      if (clr_i)     cnt_q <= '0;
      else if (wr_i) cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
      if (clr_i)                  par_err_o <= 1'b0;
      else if (wr_i && !(^byte_i)) par_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dcs_keystore.sv
module dcs_keystore #(
  parameter int unsigned KEY_BYTES = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BANKS     = 2,
  localparam int unsigned KEY_W    = KEY_BYTES * BYTE_W,
  localparam int unsigned SLOT_W   = $clog2(KEY_BYTES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [BANKS-1:0]           we_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [BYTE_W-1:0]          byte_i,
  output logic [BANKS-1:0][KEY_W-1:0] key_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar s = 0; s < KEY_BYTES; s++) begin : g_slot
      logic [BYTE_W-1:0] mem_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q <= '0;
        else if (we_i[b] && slot_i == SLOT_W'(s)) mem_q <= byte_i;
      end
      assign key_o[b][s*BYTE_W +: BYTE_W] = mem_q;
    end
  end
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int unsigned KEY_BYTES = 8,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned KEY_W    = KEY_BYTES * BYTE_W,
  localparam int unsigned SLOT_W   = $clog2(KEY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              direct_mode_i,
  input  logic [BYTE_W-1:0] aux_i,
  input  logic              aux_wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              data_wr_i,
  output logic              start_enc_o,
  output logic              start_dec_o,
  output logic              stop_o,
  output logic              enc_we_o,
  output logic              dec_we_o,
  output logic              key_done_o,
  output logic              parity_err_o,
  output logic              sel_err_o,
  output logic [KEY_W-1:0]  enc_key_o,
  output logic [KEY_W-1:0]  dec_key_o
);
  logic              key_rise, key_open, wr, last;
  key_tgt_e          tgt_q, tgt;
  logic [BYTE_W-1:0] wbyte;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        we;
  logic [1:0][KEY_W-1:0] keys;

  dcs_ctl #(.AUX_W(BYTE_W)) i_ctl (
    .clk_i, .rst_ni,
    .direct_i   (direct_mode_i),
    .aux_i      (aux_i),
    .start_enc_o(start_enc_o),
    .start_dec_o(start_dec_o),
    .stop_o     (stop_o),
    .key_rise_o (key_rise),
    .key_open_o (key_open),
    .tgt_o      (tgt_q),
    .sel_err_o  (sel_err_o)
  );

  assign wr    = direct_mode_i ? (data_wr_i & key_open) : aux_wr_i;
  assign wbyte = direct_mode_i ? data_i : aux_i;
  assign tgt   = direct_mode_i ? tgt_q : TGT_ENC;
  assign we[TGT_ENC] = wr & (tgt == TGT_ENC);
  assign we[TGT_DEC] = wr & (tgt == TGT_DEC);

  dcs_keyload #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W)) i_load (
    .clk_i, .rst_ni,
    .clr_i    (key_rise),
    .wr_i     (wr),
    .byte_i   (wbyte),
    .slot_o   (slot),
    .last_o   (last),
    .par_err_o(parity_err_o)
  );

  dcs_keystore #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W), .BANKS(2)) i_store (
    .clk_i, .rst_ni,
    .we_i  (we),
    .slot_i(slot),
    .byte_i(wbyte),
    .key_o (keys)
  );

  assign enc_key_o = keys[TGT_ENC];
  assign dec_key_o = keys[TGT_DEC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_we_o   <= 1'b0;
      dec_we_o   <= 1'b0;
      key_done_o <= 1'b0;
    end else begin
      enc_we_o   <= we[TGT_ENC];
      dec_we_o   <= we[TGT_DEC];
      key_done_o <= last;
    end
  end
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       direct_mode_i,
  input logic [7:0] aux_i,
  input logic       start_enc_o,
  input logic       start_dec_o,
  input logic       stop_o,
  input logic       enc_we_o,
  input logic       dec_we_o,
  input logic       key_done_o,
  input logic       parity_err_o,
  input logic       sel_err_o
);
  assert_one_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_enc_o, start_dec_o, stop_o}));
  assert_start_enc_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_enc_o |-> $past(direct_mode_i) && $past(aux_i[5]) && $past(aux_i[6]));
  assert_start_dec_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_dec_o |-> $past(direct_mode_i) && $past(aux_i[5]) && !$past(aux_i[6]));
  assert_stop_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(direct_mode_i) && !$past(aux_i[5]));
  assert_one_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({enc_we_o, dec_we_o}));
  assert_done_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done_o |-> (enc_we_o || dec_we_o));
  assert_parity_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(parity_err_o) |-> $past(direct_mode_i) && $past(aux_i[7]));
  assert_sel_err_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_err_o) |-> $past(direct_mode_i));
endmodule

bind dcs_seq dcs_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .direct_mode_i(direct_mode_i),
  .aux_i        (aux_i),
  .start_enc_o  (start_enc_o),
  .start_dec_o  (start_dec_o),
  .stop_o       (stop_o),
  .enc_we_o     (enc_we_o),
  .dec_we_o     (dec_we_o),
  .key_done_o   (key_done_o),
  .parity_err_o (parity_err_o),
  .sel_err_o    (sel_err_o)
);

// File: tb/test_dcs_seq.sv
module test_dcs_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        direct_mode_i = 1'b0;
  logic [7:0]  aux_i = '0;
  logic        aux_wr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        data_wr_i = 1'b0;
  logic        start_enc_o, start_dec_o, stop_o, enc_we_o, dec_we_o;
  logic        key_done_o, parity_err_o, sel_err_o;
  logic [63:0] enc_key_o, dec_key_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcs_seq i_dcs_seq (
    .clk_i(clk), .rst_ni, .direct_mode_i, .aux_i, .aux_wr_i, .data_i, .data_wr_i,
    .start_enc_o, .start_dec_o, .stop_o, .enc_we_o, .dec_we_o,
    .key_done_o, .parity_err_o, .sel_err_o, .enc_key_o, .dec_key_o
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // aux control: bit7 key entry, bit6 select, bit5 run
  task automatic ctl(logic key, logic sel, logic run);
    aux_i = {key, sel, run, 5'b0};
  endtask

  task automatic t_reset();
    check("R1 events", {start_enc_o, start_dec_o, stop_o}, 0);
    check("R1 strobes", {enc_we_o, dec_we_o, key_done_o}, 0);
    check("R1 flags", {parity_err_o, sel_err_o}, 0);
    check("R1 enc key", enc_key_o, 0);
    check("R1 dec key", dec_key_o, 0);
  endtask

  task automatic t_start_stop();
    direct_mode_i = 1'b1;
    ctl(0, 1, 0); step();
    ctl(0, 1, 1); step();
    check("R2 start enc", {start_enc_o, start_dec_o, stop_o}, 3'b100);
    step();
    check("R2 single pulse", {start_enc_o, start_dec_o, stop_o}, 3'b000);
    ctl(0, 1, 0); step();
    check("R3 stop", {start_enc_o, start_dec_o, stop_o}, 3'b001);
    ctl(0, 0, 0); step();
    check("R3 single pulse", {start_enc_o, start_dec_o, stop_o}, 3'b000);
    ctl(0, 0, 1); step();
    check("R2 start dec", {start_enc_o, start_dec_o, stop_o}, 3'b010);
    ctl(0, 0, 0); step();
    check("R3 stop after dec", stop_o, 1);
    check("R9 no err when idle", sel_err_o, 0);
  endtask

  task automatic t_mux_ignore();
    direct_mode_i = 1'b0;
    ctl(0, 1, 1); step();
    check("R4 no start in mux", {start_enc_o, start_dec_o, stop_o}, 0);
    ctl(0, 1, 0); step();
    check("R4 no stop in mux", {start_enc_o, start_dec_o, stop_o}, 0);
    data_i = 8'h01; data_wr_i = 1'b1; step(); data_wr_i = 1'b0;
    check("R10 mux data_wr ignored", {enc_we_o, dec_we_o}, 0);
    check("R10 mux keys untouched", enc_key_o | dec_key_o, 0);
  endtask

  task automatic t_key_direct(logic sel, logic [63:0] key);
    direct_mode_i = 1'b1;
    ctl(1, sel, 0); step();
    for (int i = 0; i < 8; i++) begin
      data_i = key[63-8*i -: 8]; data_wr_i = 1'b1; step();
      check("R5 strobe", {enc_we_o, dec_we_o}, sel ? 2'b10 : 2'b01);
      check("R7 done", key_done_o, (i == 7));
    end
    data_wr_i = 1'b0;
    step();
    check("R5 strobe ends", {enc_we_o, dec_we_o, key_done_o}, 0);
    check("R6 key order", sel ? enc_key_o : dec_key_o, key);
    check("R8 good parity", parity_err_o, 0);
    ctl(0, sel, 0); step();
  endtask

  task automatic t_direct_ignored();
    logic [63:0] e0, d0;
    e0 = enc_key_o; d0 = dec_key_o;
    direct_mode_i = 1'b1;
    ctl(0, 1, 0);
    data_i = 8'h7F; data_wr_i = 1'b1; step(); data_wr_i = 1'b0;
    check("R10 key line low", {enc_we_o, dec_we_o}, 0);
    aux_wr_i = 1'b1; step(); aux_wr_i = 1'b0;
    check("R10 aux_wr in direct", {enc_we_o, dec_we_o}, 0);
    check("R10 enc unchanged", enc_key_o, e0);
    check("R10 dec unchanged", dec_key_o, d0);
  endtask

  task automatic t_key_mux();
    logic [63:0] k;
    k = 64'h23456789ABCDEF10;
    direct_mode_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      aux_i = k[63-8*i -: 8]; aux_wr_i = 1'b1; step();
      check("R4 mux strobe", {enc_we_o, dec_we_o}, 2'b10);
      check("R7 mux done", key_done_o, (i == 7));
    end
    aux_wr_i = 1'b0; aux_i = '0;
    check("R4 mux enc key", enc_key_o, k);
    check("R8 mux parity ok", parity_err_o, 0);
  endtask

  task automatic t_parity();
    direct_mode_i = 1'b0;
    aux_i = 8'h03; aux_wr_i = 1'b1; step();
    check("R8 even byte flags", parity_err_o, 1);
    aux_i = 8'h01; step(); aux_wr_i = 1'b0;
    check("R8 sticky", parity_err_o, 1);
    step();
    check("R8 still sticky", parity_err_o, 1);
    direct_mode_i = 1'b1;
    ctl(1, 0, 0); step();
    check("R8 cleared by key entry", parity_err_o, 0);
    ctl(0, 0, 0); step();
  endtask

  task automatic t_sel_err();
    direct_mode_i = 1'b1;
    ctl(1, 0, 0); step();
    ctl(1, 1, 0); step();
    check("R9 select moved", sel_err_o, 1);
    data_i = 8'hC4; data_wr_i = 1'b1; step(); data_wr_i = 1'b0;
    check("R9 target kept dec", {enc_we_o, dec_we_o}, 2'b01);
    check("R7 restart at top", dec_key_o[63:56], 8'hC4);
    step();
    check("R9 err sticky", sel_err_o, 1);
    ctl(0, 1, 0); step();
    ctl(0, 1, 1); step();
    check("R9 cleared by start", sel_err_o, 0);
    check("R2 start after err", start_enc_o, 1);
    ctl(0, 1, 0); step();
  endtask

  task automatic t_concurrent();
    logic [63:0] k;
    k = 64'h0102040810204080;
    direct_mode_i = 1'b1;
    ctl(1, 1, 0); step();
    for (int i = 0; i < 7; i++) begin
      data_i = k[63-8*i -: 8]; data_wr_i = 1'b1; step();
    end
    data_i = k[7:0]; ctl(1, 1, 1); step(); data_wr_i = 1'b0;
    check("R2 start with last byte", {start_enc_o, start_dec_o, stop_o}, 3'b100);
    check("R7 done with start", {enc_we_o, key_done_o}, 2'b11);
    check("R6 concurrent key", enc_key_o, k);
    check("R9 no err concurrent", sel_err_o, 0);
    data_i = 8'hFE; data_wr_i = 1'b1; step(); data_wr_i = 1'b0;
    check("R7 wrap to top", enc_key_o[63:56], 8'hFE);
    ctl(1, 1, 0); step();
    check("R3 stop in key entry", stop_o, 1);
    ctl(0, 1, 0); step();
  endtask

  initial begin
    repeat (3) step();
    check("R1 in reset", {enc_we_o, start_enc_o, parity_err_o}, 0);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_start_stop();
    t_mux_ignore();
    t_key_direct(1'b1, 64'h0102040810204080);
    t_key_direct(1'b0, 64'h070B0D0E13151619);
    t_direct_ignored();
    t_key_mux();
    t_parity();
    t_sel_err();
    t_concurrent();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule